// File: doc/BRIEF.md
# Octal Switch Channel Controller

This block keeps the configuration and command registers for eight switched output channels and decides every clock whether each channel's power stage is driven. A host writes and reads the registers through a small parallel port: a 3-bit address, an 8-bit write bus with a strobe, and an 8-bit registered read bus. One shared pin input can be routed to any subset of channels. For each channel that receives the pin, a per-channel choice of AND or OR combines it with the channel's serial command bit.

Every channel has an overload flag and an overtemperature flag as inputs. For each kind of fault, a per-channel setting selects between two responses. One keeps the channel running, or stops it only while the flag is present. The other turns the channel off and holds it off until the host writes a 0 to that channel's command bit. Per-channel slow-slew selects are driven straight from a register. The actual drive state can be read back at address 6.

Top module: `oc_ctrl`

## Requirements
- R1: After reset, address 1 (pin routing) reads 08h, so only channel 3 (bit 3) receives the pin. Addresses 2, 3, 4, 5 and 7 read 00h, and every drive and slew output is 0.
- R2: A strobed write to address 1 (routing), 2 (combine), 3 (overload mode), 4 (overtemperature mode), 5 (slew) or 7 (command) stores the data. Bit i belongs to channel i. A read presents the addressed register on rdata one clock later.
- R3: Address 0 is unused. Writes to it change nothing, and reads return 00h.
- R4: Address 6 reads the present drive outputs. Writes to address 6 are ignored.
- R5: A channel whose routing bit is 0 sees the pin as 0.
- R6: With combine bit 0, a channel's command is its command bit OR its routed pin.
- R7: With combine bit 1, a channel's command is its command bit AND its routed pin.
- R8: With overload mode bit 0, an overload flag has no effect on the channel's drive.
- R9: With overload mode bit 1, an overload flag turns the channel off. The channel stays off after the flag clears, until a write to address 7 with that channel's bit at 0 is made while no fault is active on the channel.
- R10: With overtemperature mode bit 0, the channel is off while its flag is high and resumes on its own once the flag is low.
- R11: With overtemperature mode bit 1, an overtemperature flag turns the channel off and holds it off, with the same release as R9.
- R12: slow_sel bit i equals the channel i bit of the slew register (1 = slow, 0 = fast).
- R13: Drive outputs are registered. A pin or flag change shows at the first rising edge that samples it. A register write shows one edge after the edge that captures the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| rdata | output | 8 | Registered read data |
| pin_in | input | 1 | Shared parallel control pin |
| ovl_flag | input | 8 | Per-channel overload indication |
| ovt_flag | input | 8 | Per-channel overtemperature indication |
| drive_en | output | 8 | Per-channel power stage enable |
| slow_sel | output | 8 | Per-channel slow-slew select |

## Verification
Pin and flag changes reach drive_en at the first rising edge after the bench applies them. A register write needs two edges: one to capture the value and one to recompute the drive. Read data and slow_sel follow one edge after their cause. The bench changes inputs on falling edges and updates its behavioural model on the same rising edge the design uses. It compares at the next falling edge. Directed checks sample exactly at those edges, including a check that a written command has not yet reached the drive one edge after capture.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int ADDR_W     = 3;
  localparam int CH_DEFAULT = 8;

  localparam logic [ADDR_W-1:0] ADR_NONE = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_ROUT = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_COMB = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_OVLM = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_OVTM = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_SLEW = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_CMD  = 3'd7;
endpackage

// File: rtl/oc_regfile.sv
module oc_regfile
  import oc_pkg::*;
#(
  parameter int NCH = CH_DEFAULT,
  parameter logic [NCH-1:0] ROUT_INIT = 'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    wdata,
  output logic [NCH-1:0]    rout_q,
  output logic [NCH-1:0]    comb_q,
  output logic [NCH-1:0]    ovlm_q,
  output logic [NCH-1:0]    ovtm_q,
  output logic [NCH-1:0]    slew_q,
  output logic [NCH-1:0]    cmd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rout_q <= ROUT_INIT;
      comb_q <= '0;
      ovlm_q <= '0;
      ovtm_q <= '0;
      slew_q <= '0;
      cmd_q  <= '0;
    end else if (we) begin
      case (addr)
        ADR_ROUT: rout_q <= wdata;
        ADR_COMB: comb_q <= wdata;
        ADR_OVLM: ovlm_q <= wdata;
        ADR_OVTM: ovtm_q <= wdata;
        ADR_SLEW: slew_q <= wdata;
        ADR_CMD:  cmd_q  <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/oc_rdmux.sv
module oc_rdmux
  import oc_pkg::*;
#(
  parameter int NCH = CH_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    rout_q,
  input  logic [NCH-1:0]    comb_q,
  input  logic [NCH-1:0]    ovlm_q,
  input  logic [NCH-1:0]    ovtm_q,
  input  logic [NCH-1:0]    slew_q,
  input  logic [NCH-1:0]    cmd_q,
  input  logic [NCH-1:0]    stat,
  output logic [NCH-1:0]    rdata
);
  logic [NCH-1:0] sel;

  always_comb begin
    case (addr)
      ADR_ROUT: sel = rout_q;
      ADR_COMB: sel = comb_q;
      ADR_OVLM: sel = ovlm_q;
      ADR_OVTM: sel = ovtm_q;
      ADR_SLEW: sel = slew_q;
      ADR_STAT: sel = stat;
      ADR_CMD:  sel = cmd_q;
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end
endmodule

// File: rtl/oc_chan.sv
module oc_chan (
  input  logic clk,
  input  logic rst,
  input  logic routed,
  input  logic use_and,
  input  logic ovl_hold,
  input  logic ovt_hold,
  input  logic ser_on,
  input  logic release_req,
  input  logic pin,
  input  logic ovl,
  input  logic ovt,
  output logic drive
);
  logic par, want, trip, block_now, hold_q;

  always_comb begin
    par       = routed & pin;
    want      = use_and ? (ser_on & par) : (ser_on | par);
    trip      = (ovl & ovl_hold) | (ovt & ovt_hold);
    block_now = ovt | (ovl & ovl_hold) | hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      drive  <= 1'b0;
    end else begin
      hold_q <= trip | (hold_q & ~release_req);
      drive  <= want & ~block_now;
    end
  end
endmodule

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
#(
  parameter int NCH = CH_DEFAULT,
  parameter logic [NCH-1:0] ROUT_INIT = 'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    wdata,
  input  logic              we,
  output logic [NCH-1:0]    rdata,
  input  logic              pin_in,
  input  logic [NCH-1:0]    ovl_flag,
  input  logic [NCH-1:0]    ovt_flag,
  output logic [NCH-1:0]    drive_en,
  output logic [NCH-1:0]    slow_sel
);
  logic [NCH-1:0] rout_q, comb_q, ovlm_q, ovtm_q, slew_q, cmd_q;
  logic [NCH-1:0] release_vec;
  logic           cmd_wr;

  assign cmd_wr      = we && (addr == ADR_CMD);
  assign release_vec = {NCH{cmd_wr}} & ~wdata;
  assign slow_sel    = slew_q;

  oc_regfile #(.NCH(NCH), .ROUT_INIT(ROUT_INIT)) u_regs (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
    .rout_q(rout_q), .comb_q(comb_q), .ovlm_q(ovlm_q), .ovtm_q(ovtm_q),
    .slew_q(slew_q), .cmd_q(cmd_q)
  );

  oc_rdmux #(.NCH(NCH)) u_rd (
    .clk(clk), .rst(rst), .addr(addr),
    .rout_q(rout_q), .comb_q(comb_q), .ovlm_q(ovlm_q), .ovtm_q(ovtm_q),
    .slew_q(slew_q), .cmd_q(cmd_q), .stat(drive_en), .rdata(rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    oc_chan u_ch (
      .clk(clk), .rst(rst),
      .routed(rout_q[i]), .use_and(comb_q[i]),
      .ovl_hold(ovlm_q[i]), .ovt_hold(ovtm_q[i]),
      .ser_on(cmd_q[i]), .release_req(release_vec[i]),
      .pin(pin_in), .ovl(ovl_flag[i]), .ovt(ovt_flag[i]),
      .drive(drive_en[i])
    );
  end
endmodule

// File: rtl/oc_ctrl_chk.sv
module oc_ctrl_chk
  import oc_pkg::*;
#(
  parameter int NCH = CH_DEFAULT
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic [NCH-1:0]    rdata,
  input logic [NCH-1:0]    ovl_flag,
  input logic [NCH-1:0]    ovt_flag,
  input logic [NCH-1:0]    drive_en,
  input logic [NCH-1:0]    slow_sel,
  input logic [NCH-1:0]    ovl_mode,
  input logic [NCH-1:0]    comb_mode,
  input logic [NCH-1:0]    rout_mode
);
  // R10
  ovt_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_en & $past(ovt_flag)) == '0);

  // R9
  ovl_trip_off_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_en & $past(ovl_flag & ovl_mode)) == '0);

  // R3
  unused_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADR_NONE) |-> (rdata == '0));

  // R4
  status_read_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADR_STAT) |-> (rdata == $past(drive_en)));

  // R12
  slew_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !($past(we) && $past(addr) == ADR_SLEW) |-> $stable(slow_sel));

  // R5
  unrouted_and_off_chk: assert property (@(posedge clk) disable iff (rst)
    (drive_en & $past(comb_mode & ~rout_mode)) == '0);
endmodule

bind oc_ctrl oc_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .we(we), .rdata(rdata),
  .ovl_flag(ovl_flag), .ovt_flag(ovt_flag), .drive_en(drive_en),
  .slow_sel(slow_sel), .ovl_mode(ovlm_q), .comb_mode(comb_q),
  .rout_mode(rout_q)
);

// File: tb/tb_oc_ctrl.sv
`timescale 1ns/1ps
module tb_oc_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       pin_in = 1'b0;
  logic [7:0] ovl_flag = '0;
  logic [7:0] ovt_flag = '0;
  logic [7:0] drive_en;
  logic [7:0] slow_sel;

  always #2.5 clk = ~clk;

  oc_ctrl dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we), .rdata(rdata),
    .pin_in(pin_in), .ovl_flag(ovl_flag), .ovt_flag(ovt_flag),
    .drive_en(drive_en), .slow_sel(slow_sel)
  );

  int    nvec = 0;
  int    nfail = 0;
  bit    run = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural model state
  bit [7:0] m_rout, m_comb, m_ovlm, m_ovtm, m_slew, m_cmd, m_drv, m_hold, m_rd;
  bit [7:0] n_drv, n_hold;
  bit       m_par, m_want;

  always @(posedge clk) begin
    if (rst) begin
      m_rout = 8'h08; m_comb = 0; m_ovlm = 0; m_ovtm = 0; m_slew = 0; m_cmd = 0;
      m_drv = 0; m_hold = 0; m_rd = 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        m_par  = m_rout[i] && pin_in;
        m_want = m_comb[i] ? (m_cmd[i] && m_par) : (m_cmd[i] || m_par);
        n_drv[i] = m_want && !m_hold[i] && !ovt_flag[i] && !(ovl_flag[i] && m_ovlm[i]);
        n_hold[i] = (ovl_flag[i] && m_ovlm[i]) || (ovt_flag[i] && m_ovtm[i]) ||
                    (m_hold[i] && !(we && addr == 3'd7 && !wdata[i]));
      end
      case (addr)
        3'd1: m_rd = m_rout;
        3'd2: m_rd = m_comb;
        3'd3: m_rd = m_ovlm;
        3'd4: m_rd = m_ovtm;
        3'd5: m_rd = m_slew;
        3'd6: m_rd = m_drv;
        3'd7: m_rd = m_cmd;
        default: m_rd = 0;
      endcase
      if (we) begin
        case (addr)
          3'd1: m_rout = wdata;
          3'd2: m_comb = wdata;
          3'd3: m_ovlm = wdata;
          3'd4: m_ovtm = wdata;
          3'd5: m_slew = wdata;
          3'd7: m_cmd  = wdata;
          default: ;
        endcase
      end
      m_drv  = n_drv;
      m_hold = n_hold;
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      chk(cur_req, "drive_en", drive_en, m_drv);
      chk(cur_req, "slow_sel", slow_sel, m_slew);
      chk(cur_req, "rdata", rdata, m_rd);
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; addr = 3'd0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    chk(req, "read", rdata, exp);
    addr = 3'd0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run = 1;
    // R1 reset values
    cur_req = "R1";
    chk("R1", "drive reset", drive_en, 8'h00);
    chk("R1", "slew reset", slow_sel, 8'h00);
    rd(3'd1, 8'h08, "R1");
    rd(3'd2, 8'h00, "R1");
    rd(3'd4, 8'h00, "R1");
    rd(3'd7, 8'h00, "R1");

    // R2 write and readback
    cur_req = "R2";
    wr(3'd2, 8'h5A); rd(3'd2, 8'h5A, "R2");
    wr(3'd3, 8'h00); rd(3'd3, 8'h00, "R2");
    wr(3'd4, 8'h00); rd(3'd4, 8'h00, "R2");
    wr(3'd1, 8'hC3); rd(3'd1, 8'hC3, "R2");
    wr(3'd2, 8'h00);

    // R3 unused address
    cur_req = "R3";
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h00, "R3");
    rd(3'd1, 8'hC3, "R3");
    idle(1);
    chk("R3", "drive after addr0 write", drive_en, 8'h00);

    // R12 slew select
    cur_req = "R12";
    wr(3'd5, 8'hA5);
    chk("R12", "slow_sel", slow_sel, 8'hA5);

    // R6 OR combine, R13 timing
    cur_req = "R6";
    wr(3'd1, 8'h0F);
    wr(3'd7, 8'h30);
    chk("R13", "drive one edge after capture", drive_en, 8'h00);
    idle(1);
    chk("R6", "or serial only", drive_en, 8'h30);
    @(negedge clk) pin_in = 1'b1;
    @(negedge clk);
    chk("R13", "pin one edge", drive_en, 8'h3F);
    chk("R6", "or with pin", drive_en, 8'h3F);
    pin_in = 1'b0;
    idle(1);
    chk("R6", "or pin low", drive_en, 8'h30);

    // R7 AND combine, R5 routing
    cur_req = "R7";
    wr(3'd2, 8'hFF);
    wr(3'd1, 8'hF0);
    wr(3'd7, 8'h3C);
    idle(1);
    chk("R7", "and pin low", drive_en, 8'h00);
    @(negedge clk) pin_in = 1'b1;
    @(negedge clk);
    chk("R7", "and pin high", drive_en, 8'h30);
    chk("R5", "unrouted under and off", drive_en & 8'h0F, 8'h00);
    cur_req = "R5";
    wr(3'd2, 8'h00);
    idle(1);
    chk("R5", "unrouted under or follows serial", drive_en, 8'hFC);
    pin_in = 1'b0;

    // R4 status
    cur_req = "R4";
    wr(3'd1, 8'h00);
    wr(3'd7, 8'hFF);
    idle(1);
    rd(3'd6, 8'hFF, "R4");
    wr(3'd6, 8'h00);
    idle(1);
    chk("R4", "status write ignored", drive_en, 8'hFF);
    rd(3'd6, 8'hFF, "R4");

    // R8 overload ignored
    cur_req = "R8";
    @(negedge clk) ovl_flag = 8'h08;
    idle(2);
    chk("R8", "overload no effect", drive_en, 8'hFF);
    ovl_flag = 8'h00;

    // R9 latched overload
    cur_req = "R9";
    wr(3'd3, 8'h01);
    @(negedge clk) ovl_flag = 8'h01;
    @(negedge clk);
    chk("R9", "overload trips", drive_en, 8'hFE);
    ovl_flag = 8'h00;
    idle(3);
    chk("R9", "overload held", drive_en, 8'hFE);
    wr(3'd7, 8'hFF);
    idle(1);
    chk("R9", "set without release held", drive_en, 8'hFE);
    wr(3'd7, 8'hFE);
    wr(3'd7, 8'hFF);
    idle(1);
    chk("R9", "released and back on", drive_en, 8'hFF);

    // R10 auto restart overtemperature
    cur_req = "R10";
    @(negedge clk) ovt_flag = 8'h04;
    @(negedge clk);
    chk("R10", "ovt off", drive_en, 8'hFB);
    ovt_flag = 8'h00;
    @(negedge clk);
    chk("R10", "ovt restart", drive_en, 8'hFF);

    // R11 latched overtemperature
    cur_req = "R11";
    wr(3'd4, 8'h02);
    @(negedge clk) ovt_flag = 8'h02;
    @(negedge clk);
    chk("R11", "ovt trip", drive_en, 8'hFD);
    ovt_flag = 8'h00;
    idle(3);
    chk("R11", "ovt held", drive_en, 8'hFD);
    wr(3'd7, 8'hFD);
    wr(3'd7, 8'hFF);
    idle(1);
    chk("R11", "ovt released", drive_en, 8'hFF);

    // mixed pattern sweep against the model
    cur_req = "R13";
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      pin_in   = k[0];
      ovl_flag = 8'(k * 37) & 8'h11;
      ovt_flag = 8'(k * 53) & 8'h42;
    end
    ovl_flag = 0; ovt_flag = 0;
    idle(4);
    summary();
  end
endmodule